// File: doc/BRIEF.md
# Modem Line Status Register with Change Tracking

This block is the modem status register of a 16550-class serial port. It takes four active-low handshake lines from the attached modem or peripheral: clear-to-send, data-set-ready, ring indicator and carrier detect. It passes each one through a two-flop synchronizer. The upper nibble of the register gives the current levels, inverted so that 1 means the line is asserted. The lower nibble holds sticky flags that record a change on each line since the register was last read.

A read strobe whose register address equals 6 clears the flags. The divisor-latch access bit plays no part in this decode. If a line change is detected in the same clock cycle as the clearing read, its flag stays set, so no event is lost between two reads. When the modem-status interrupt enable is high, the block raises an interrupt request for as long as any flag is set. Decoding of the host bus beyond the 3-bit register address, interrupt prioritisation and all other UART registers belong to neighbouring blocks.

Top module: `msr_top`

## Requirements
- R1: During and right after a synchronous reset with all four lines inactive (high), `rd_data` is 8'h00 and `ms_irq` is 0.
- R2: `rd_data` bit 4 equals the inverse of `cts_n`, bit 5 the inverse of `dsr_n`, bit 6 the inverse of `ri_n` and bit 7 the inverse of `dcd_n`. Each takes the new value after the second rising clock edge that follows an input change.
- R3: Bit 0 is set after the third rising edge that follows any change of `cts_n`. It stays set until a clearing read.
- R4: Bit 1 is set after the third rising edge that follows any change of `dsr_n`. It stays set until a clearing read.
- R5: Bit 2 is set only when `ri_n` goes from low to high (ring ends). A high-to-low change of `ri_n` leaves bit 2 at 0.
- R6: Bit 3 is set after the third rising edge that follows any change of `dcd_n`, in either direction.
- R7: A clock edge with `rd_stb` high and `rd_addr` equal to 3'd6 clears bits 3:0. A strobe with any other address leaves them unchanged.
- R8: A change that reaches detection in the same cycle as a clearing read leaves its flag at 1 after that edge.
- R9: `ms_irq` is 1 exactly when `ms_ie` is 1 and at least one of bits 3:0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register address of the access |
| ms_ie | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| rd_data | output | 8 | Register contents: levels in 7:4, change flags in 3:0 |
| ms_irq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a line change whose detection falls in exactly the same cycle as a clearing read. Because of the synchronizer, the strobe has to arrive two edges after the pin moves. A directed test counts those edges, places the strobe there and then checks that the flag is still set. The random phase toggles lines and issues reads at both the matching and the other addresses at high rates, so it also hits many of these overlaps. It hits ring-onset and ring-end transitions as well, and a cycle-level reference model checks every cycle.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int unsigned LINES      = 4;
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned REG_W      = 2 * LINES;
    localparam logic [ADDR_W-1:0] MSR_OFFSET = 3'd6;

    // Line index within the nibble; positions are decoded by the host.
    localparam int unsigned IDX_CTS = 0;
    localparam int unsigned IDX_DSR = 1;
    localparam int unsigned IDX_RI  = 2;
    localparam int unsigned IDX_DCD = 3;

    typedef enum logic [1:0] {
        EDGE_ANY  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_mode_e;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_t;

    typedef struct packed {
        modem_t level;
        modem_t delta;
    } msr_reg_t;

    // Ring indicator only reports the end of a ring: active-low pin rising.
    function automatic edge_mode_e line_mode(int unsigned idx);
        return (idx == IDX_RI) ? EDGE_RISE : EDGE_ANY;
    endfunction

    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        logic hit;
        case (mode)
            EDGE_RISE: hit = !prev && cur;
            EDGE_FALL: hit = prev && !cur;
            default:   hit = prev ^ cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
#(
    parameter int unsigned W = LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_n,
    input  logic         clr,
    output logic [W-1:0] chg,
    output logic [W-1:0] flags
);

    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        assign chg[i] = edge_hit(line_mode(i), prev_q[i], line_n[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b1;
                flag_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= line_n[i];
                // a change seen during a clearing read survives it
                flag_q[i] <= clr ? chg[i] : (flag_q[i] | chg[i]);
            end
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/msr_top.sv
module msr_top (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_stb,
    input  logic [2:0] rd_addr,
    input  logic       ms_ie,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    output logic [7:0] rd_data,
    output logic       ms_irq
);
    import msr_pkg::*;

    logic [LINES-1:0] raw_n;
    logic [LINES-1:0] sync_n;
    logic [LINES-1:0] chg_w;
    logic [LINES-1:0] flag_w;
    logic             rd_hit;
    msr_reg_t         reg_v;

    assign raw_n[IDX_CTS] = cts_n;
    assign raw_n[IDX_DSR] = dsr_n;
    assign raw_n[IDX_RI]  = ri_n;
    assign raw_n[IDX_DCD] = dcd_n;

    assign rd_hit = rd_stb && (rd_addr == MSR_OFFSET);

    msr_sync #(
        .W      (LINES),
        .STAGES (SYNC_DEPTH),
        .RST_VAL({LINES{1'b1}})
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_n),
        .q   (sync_n)
    );

    msr_delta #(
        .W (LINES)
    ) delta_i (
        .clk   (clk),
        .rst   (rst),
        .line_n(sync_n),
        .clr   (rd_hit),
        .chg   (chg_w),
        .flags (flag_w)
    );

    assign reg_v.level = modem_t'(~sync_n);
    assign reg_v.delta = modem_t'(flag_w);

    assign rd_data = REG_W'(reg_v);
    assign ms_irq  = ms_ie && (|flag_w);

endmodule

// File: rtl/msr_chk.sv
module msr_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_hit,
    input logic       ms_ie,
    input logic       ms_irq,
    input logic [7:0] rd_data,
    input logic [3:0] raw_n,
    input logic [3:0] chg_w
);

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)               age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (rd_data[7:4] == ~$past(raw_n, 2))); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0]))); // R3

    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> (rd_data[3:0] == $past(chg_w))); // R7

    AST_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
        (|chg_w) |=> ((rd_data[3:0] & $past(chg_w)) == $past(chg_w))); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !ms_ie |-> !ms_irq); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ms_irq |-> (rd_data[3:0] != 4'h0)); // R9

endmodule

bind msr_top msr_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (rd_hit),
    .ms_ie  (ms_ie),
    .ms_irq (ms_irq),
    .rd_data(rd_data),
    .raw_n  (raw_n),
    .chg_w  (chg_w)
);

// File: tb/msr_top_tb.sv
`timescale 1ns/1ps
module msr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       rd_stb;
    logic [2:0] rd_addr;
    logic       ms_ie;
    logic       cts_n, dsr_n, ri_n, dcd_n;
    logic [7:0] rd_data;
    logic       ms_irq;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    msr_top dut_i (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .rd_addr(rd_addr),
        .ms_ie  (ms_ie),
        .cts_n  (cts_n),
        .dsr_n  (dsr_n),
        .ri_n   (ri_n),
        .dcd_n  (dcd_n),
        .rd_data(rd_data),
        .ms_irq (ms_irq)
    );

    // Reference model built from the requirement timing: two sync edges, one detect edge.
    logic [3:0] m_s1, m_s2, m_prev, m_flag;

    function automatic logic [3:0] exp_chg(logic [3:0] prev, logic [3:0] cur);
        logic [3:0] c;
        c    = prev ^ cur;
        c[2] = !prev[2] && cur[2];       // R5: ring end only
        return c;
    endfunction

    function automatic logic [7:0] exp_reg();
        return {~m_s2[3], ~m_s2[2], ~m_s2[1], ~m_s2[0], m_flag};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1   <= 4'hF;
            m_s2   <= 4'hF;
            m_prev <= 4'hF;
            m_flag <= 4'h0;
        end else begin
            m_s1   <= {dcd_n, ri_n, dsr_n, cts_n};
            m_s2   <= m_s1;
            m_prev <= m_s2;
            if (rd_stb && rd_addr == 3'd6) m_flag <= exp_chg(m_prev, m_s2);
            else                           m_flag <= m_flag | exp_chg(m_prev, m_s2);
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic clear_read();
        rd_stb = 1'b1; rd_addr = 3'd6;
        tick();
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd51773);
        rst = 1'b1; rd_stb = 1'b0; rd_addr = 3'd0; ms_ie = 1'b0;
        cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
        tick(3);
        check("R1 reset data", rd_data, 8'h00);
        check("R1 reset irq", {7'd0, ms_irq}, 8'h00);
        rst = 1'b0;
        tick();
        check("R1 after reset", rd_data, 8'h00);

        // R2 / R3: clear-to-send asserted
        cts_n = 1'b0;
        tick();
        check("R2 one edge no change", rd_data, 8'h00);
        tick();
        check("R2 level after two edges", rd_data, 8'h10);
        tick();
        check("R3 cts flag", rd_data, 8'h11);

        // R7: wrong address keeps, right address clears
        rd_stb = 1'b1; rd_addr = 3'd5;
        tick();
        rd_stb = 1'b0;
        check("R7 other address keeps", rd_data, 8'h11);
        clear_read();
        check("R7 offset 6 clears", rd_data, 8'h10);

        // R4 / R9
        ms_ie = 1'b1;
        tick();
        check("R9 no flag no irq", {7'd0, ms_irq}, 8'h00);
        dsr_n = 1'b0;
        tick(3);
        check("R4 dsr flag", rd_data, 8'h32);
        check("R9 irq raised", {7'd0, ms_irq}, 8'h01);
        ms_ie = 1'b0;
        #1;
        check("R9 irq masked", {7'd0, ms_irq}, 8'h00);
        ms_ie = 1'b1;
        clear_read();
        check("R9 irq drops on clear", {7'd0, ms_irq}, 8'h00);
        check("R7 clear dsr", rd_data, 8'h30);

        // R5: ring onset does not flag, ring end does
        ri_n = 1'b0;
        tick(4);
        check("R5 ring onset no flag", rd_data, 8'h70);
        ri_n = 1'b1;
        tick(3);
        check("R5 ring end flag", rd_data, 8'h34);
        clear_read();

        // R6: carrier detect both directions
        dcd_n = 1'b0;
        tick(3);
        check("R6 dcd assert flag", rd_data, 8'hB8);
        clear_read();
        dcd_n = 1'b1;
        tick(3);
        check("R6 dcd release flag", rd_data, 8'h38);
        clear_read();
        check("R6 cleared", rd_data, 8'h30);

        // R8: change detected in the very cycle of the clearing read
        cts_n = 1'b1;
        tick(2);
        check("R8 level before read", rd_data, 8'h20);
        clear_read();
        check("R8 flag survives read", rd_data, 8'h21);
        clear_read();
        check("R8 next read clears", rd_data, 8'h20);

        // Random phase against the reference model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 6 == 0) begin
                case ($urandom % 4)
                    0: cts_n = ~cts_n;
                    1: dsr_n = ~dsr_n;
                    2: ri_n  = ~ri_n;
                    default: dcd_n = ~dcd_n;
                endcase
            end
            rd_stb  = ($urandom % 3 == 0);
            rd_addr = ($urandom % 2 == 0) ? 3'd6 : 3'($urandom % 8);
            if ($urandom % 16 == 0) ms_ie = ~ms_ie;
            tick();
            check("R2 R3 R4 R5 R6 R7 R8 random register", rd_data, exp_reg());
            check("R9 random irq", {7'd0, ms_irq},
                  {7'd0, ms_ie && (exp_reg() & 8'h0F) != 8'h00});
        end

        finished = 1'b1;
        finish_run();
    end

endmodule